// File: doc/BRIEF.md
# Saturating Narrowing Vector Shifter

This block takes a 128-bit source vector made of double-width lanes. It shifts every lane right by an immediate amount and packs each result into a lane of half the width. Narrowing can work in two ways. The plain mode simply keeps the low bits. The three saturating modes clamp the shifted value to the range of the destination lane: signed to signed, signed to unsigned, and unsigned to unsigned. Any mode can add a rounding constant before the shift. That addition is done at a width wide enough that it never wraps.

The narrowed results form a 64-bit half. A half select places that half into the low or the high part of the destination. When the high part is written, the low part of the prior destination is carried through unchanged. When the low part is written, the high part is cleared. A scalar mode computes only element 0 and clears everything else. A sticky flag records that some element was clamped, and it stays set until the surrounding logic clears it. Each operation is one registered cycle long, so a new operation may be issued every cycle.

Top module: `nsh_top`

## Requirements
- R1: An operation presented with `in_valid` high appears on `dst_new`, with `out_valid` high, exactly one clock later. Reset drives `out_valid`, `dst_new` and `sat_flag` to 0.
- R2: The size code sets the destination element width: 0 gives 8 bits, 1 gives 16 and 2 gives 32. Source element i occupies bits [i*2W +: 2W]. A vector operation produces 8 >> size elements, and element i lands at bits [i*W +: W] of the written half.
- R3: With `rnd` = 1, the value 2^(shift-1) is added to each source element before the shift. The sum is formed at a width at least two bits wider than the source element, so it cannot wrap. For example, unsigned 0xFFFF with shift 8 rounds to 0x100.
- R4: Mode 0 (truncate) shifts logically and keeps the low W bits of the result. It never sets the saturation flag.
- R5: Mode 1 (signed to signed) shifts arithmetically and clamps to the range [-2^(W-1), 2^(W-1)-1].
- R6: Mode 2 (signed to unsigned) shifts arithmetically. A negative result becomes 0, and a result above 2^W-1 becomes 2^W-1.
- R7: Mode 3 (unsigned to unsigned) shifts logically and clamps results above 2^W-1 to 2^W-1.
- R8: In a vector operation with `upper` = 0, the results fill bits [63:0] and bits [127:64] are 0.
- R9: In a vector operation with `upper` = 1, the results fill bits [127:64] and bits [63:0] equal `dst_old[63:0]`.
- R10: With `scalar` = 1, only element 0 is computed, into bits [W-1:0]. All other bits are 0, `upper` is ignored, and only element 0 can set the flag.
- R11: `sat_flag` sets in the cycle after an accepted operation in which any computed element was clamped. It holds until `sat_clr` is high, which clears it on the next clock. When both happen in the same cycle, the clear wins.
- R12: Shift amounts from 1 up to W inclusive are supported, and shift W gives correct results for every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 128 | Source vector of double-width lanes |
| dst_old | input | 128 | Prior destination contents |
| size | input | 2 | Destination element size code (0, 1, 2) |
| shamt | input | 6 | Right shift amount, 1..W |
| mode | input | 2 | 0 truncate, 1 signed/signed, 2 signed/unsigned, 3 unsigned/unsigned |
| rnd | input | 1 | Add rounding constant before shift |
| upper | input | 1 | Write results into the high half |
| scalar | input | 1 | Compute element 0 only |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| dst_new | output | 128 | New destination contents |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
Random source vectors are run through every mode, size code, shift amount and half policy.

- Full-range random lanes clamp most of the time.
- Near-zero lanes mostly pass through, so they separate clamping errors from shift errors.
- Directed cases target the edges:
  - 0xFFFF with rounding, which tells a wide rounding sum from a wrapping one.
  - The most negative lane, which exercises the signed minimum and the negative-to-zero clamp.
  - Shift equal to W.
  - Scalar with the half select set, which shows the select is ignored.
  - A clear issued together with a saturating operation.

// File: rtl/nsh_pkg.sv
package nsh_pkg;
  typedef enum logic [1:0] {
    NSH_TRUNC = 2'd0,
    NSH_SS    = 2'd1,
    NSH_SU    = 2'd2,
    NSH_UU    = 2'd3
  } nsh_mode_e;

  localparam int NSH_NUM_SIZES = 3;
  localparam int NSH_BASE_W    = 8;
endpackage

// File: rtl/nsh_lane.sv
module nsh_lane
  import nsh_pkg::*;
#(
  parameter int DW = 8,
  parameter int SH_W = 6
) (
  input  logic [2*DW-1:0] src,
  input  logic [SH_W-1:0] shamt,
  input  nsh_mode_e       mode,
  input  logic            rnd,
  output logic [DW-1:0]   res,
  output logic            sat
);
  localparam int XW = 2*DW + 2;
  localparam logic [XW-1:0] SMAX = {{(DW+3){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [XW-1:0] SMIN = {{(DW+3){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [XW-1:0] UMAX = {{(DW+2){1'b0}}, {DW{1'b1}}};

  logic                 sgn;
  logic signed [XW-1:0] ext;
  logic signed [XW-1:0] addv;
  logic signed [XW-1:0] sum;
  logic signed [XW-1:0] shv;

  always_comb begin
    sgn  = (mode == NSH_SS) || (mode == NSH_SU);
    ext  = {{2{sgn & src[2*DW-1]}}, src};
    addv = '0;
    if (rnd && (shamt != '0)) addv = XW'(1) << (shamt - SH_W'(1));
    sum  = ext + addv;
    shv  = sum >>> shamt;
    res  = shv[DW-1:0];
    sat  = 1'b0;
    unique case (mode)
      NSH_TRUNC: begin
        res = shv[DW-1:0];
      end
      NSH_SS: begin
        if (shv > $signed(SMAX)) begin
          res = SMAX[DW-1:0];
          sat = 1'b1;
        end else if (shv < $signed(SMIN)) begin
          res = SMIN[DW-1:0];
          sat = 1'b1;
        end
      end
      NSH_SU: begin
        if (shv < 0) begin
          res = '0;
          sat = 1'b1;
        end else if (shv > $signed(UMAX)) begin
          res = UMAX[DW-1:0];
          sat = 1'b1;
        end
      end
      default: begin
        if (shv > $signed(UMAX)) begin
          res = UMAX[DW-1:0];
          sat = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/nsh_bank.sv
module nsh_bank
  import nsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int DW    = 8,
  parameter int SH_W  = 6
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [SH_W-1:0]    shamt,
  input  nsh_mode_e          mode,
  input  logic               rnd,
  input  logic               scalar,
  output logic [VEC_W/2-1:0] half,
  output logic               sat_any
);
  localparam int HALF_W = VEC_W / 2;
  localparam int LANES  = HALF_W / DW;

  logic [LANES-1:0] lane_sat;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [DW-1:0] r;
      logic          s;
      nsh_lane #(.DW(DW), .SH_W(SH_W)) u_lane (
        .src   (src[i*2*DW +: 2*DW]),
        .shamt (shamt),
        .mode  (mode),
        .rnd   (rnd),
        .res   (r),
        .sat   (s)
      );
      if (i == 0) begin : g_first
        assign half[DW-1:0] = r;
        assign lane_sat[0]  = s;
      end else begin : g_rest
        assign half[i*DW +: DW] = scalar ? '0 : r;
        assign lane_sat[i]      = s & ~scalar;
      end
    end
  endgenerate

  assign sat_any = |lane_sat;
endmodule

// File: rtl/nsh_top.sv
module nsh_top
  import nsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SH_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst_old,
  input  logic [1:0]       size,
  input  logic [SH_W-1:0]  shamt,
  input  logic [1:0]       mode,
  input  logic             rnd,
  input  logic             upper,
  input  logic             scalar,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] dst_new,
  output logic             sat_flag
);
  localparam int HALF_W = VEC_W / 2;

  nsh_mode_e          mode_e;
  logic [HALF_W-1:0]  half_by [NSH_NUM_SIZES];
  logic               sat_by  [NSH_NUM_SIZES];
  logic [HALF_W-1:0]  half_sel;
  logic               sat_sel;
  logic [VEC_W-1:0]   dst_next;

  assign mode_e = nsh_mode_e'(mode);

  genvar g;
  generate
    for (g = 0; g < NSH_NUM_SIZES; g++) begin : g_size
      nsh_bank #(.VEC_W(VEC_W), .DW(NSH_BASE_W << g), .SH_W(SH_W)) u_bank (
        .src     (src),
        .shamt   (shamt),
        .mode    (mode_e),
        .rnd     (rnd),
        .scalar  (scalar),
        .half    (half_by[g]),
        .sat_any (sat_by[g])
      );
    end
  endgenerate

  always_comb begin
    unique case (size)
      2'd0:    begin half_sel = half_by[0]; sat_sel = sat_by[0]; end
      2'd1:    begin half_sel = half_by[1]; sat_sel = sat_by[1]; end
      default: begin half_sel = half_by[2]; sat_sel = sat_by[2]; end
    endcase
    if (scalar || !upper) dst_next = {{HALF_W{1'b0}}, half_sel};
    else                  dst_next = {half_sel, dst_old[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst_new <= dst_next;
      if (sat_clr)                  sat_flag <= 1'b0;
      else if (in_valid && sat_sel) sat_flag <= 1'b1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_LOW_WRITE_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !upper && !scalar) |=> (dst_new[VEC_W-1:HALF_W] == '0)); // R8
  AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upper && !scalar) |=> (dst_new[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]))); // R9
  AST_SCALAR_ONE_ELEMENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar) |=> (dst_new[VEC_W-1:32] == '0)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sat_clr |=> !sat_flag); // R11
  AST_TRUNC_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd0 && !sat_flag) |=> !sat_flag); // R4
endmodule

// File: tb/sim_nsh_top.sv
`timescale 1ns/1ps
module sim_nsh_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic [127:0] dst_old = '0;
  logic [1:0]   size = '0;
  logic [5:0]   shamt = 6'd1;
  logic [1:0]   mode = '0;
  logic         rnd = 1'b0;
  logic         upper = 1'b0;
  logic         scalar = 1'b0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [127:0] dst_new;
  logic         sat_flag;

  int  n_checks = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  exp_flag = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  nsh_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .dst_old(dst_old),
    .size(size), .shamt(shamt), .mode(mode), .rnd(rnd), .upper(upper),
    .scalar(scalar), .sat_clr(sat_clr), .out_valid(out_valid),
    .dst_new(dst_new), .sat_flag(sat_flag)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lmask(input int w);
    return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic void ref_op(input logic [127:0] s, input logic [127:0] o,
      input int sz, input int sh, input int md, input bit rn, input bit up,
      input bit sc, output logic [127:0] d, output bit st);
    int w = 8 << sz;
    int n = sc ? 1 : (8 >> sz);
    logic [63:0] half = '0;
    st = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ln = (s >> (i*2*w)) & lmask(2*w);
      logic signed [67:0] x = $signed({4'b0, ln});
      logic signed [67:0] hi_s = (68'sd1 <<< (w-1)) - 68'sd1;
      logic signed [67:0] lo_s = -(68'sd1 <<< (w-1));
      logic signed [67:0] hi_u = (68'sd1 <<< w) - 68'sd1;
      logic [63:0] r;
      if ((md == 1 || md == 2) && ln[2*w-1]) x = x - (68'sd1 <<< (2*w));
      if (rn) x = x + (68'sd1 <<< (sh-1));
      x = x >>> sh;
      r = x[63:0];
      if (md == 1) begin
        if (x > hi_s) begin r = hi_s[63:0]; st = 1'b1; end
        else if (x < lo_s) begin r = lo_s[63:0]; st = 1'b1; end
      end else if (md == 2) begin
        if (x < 0) begin r = '0; st = 1'b1; end
        else if (x > hi_u) begin r = hi_u[63:0]; st = 1'b1; end
      end else if (md == 3) begin
        if (x > hi_u) begin r = hi_u[63:0]; st = 1'b1; end
      end
      half = half | ((r & lmask(w)) << (i*w));
    end
    d = (up && !sc) ? {half, o[63:0]} : {64'd0, half};
  endfunction

  task automatic run_op(input string tag, input logic [127:0] s, input logic [127:0] o,
      input int sz, input int sh, input int md, input bit rn, input bit up,
      input bit sc, input bit clr);
    logic [127:0] ed;
    bit est;
    ref_op(s, o, sz, sh, md, rn, up, sc, ed, est);
    exp_flag = clr ? 1'b0 : (exp_flag | est);
    @(negedge clk);
    src = s; dst_old = o; size = 2'(sz); shamt = 6'(sh); mode = 2'(md);
    rnd = rn; upper = up; scalar = sc; sat_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    check({tag, " R1 valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " data"}, dst_new, ed);
    check({tag, " R11 flag"}, {127'd0, sat_flag}, {127'd0, exp_flag});
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset data", dst_new, 128'd0);
    check("R11 reset flag", {127'd0, sat_flag}, 128'd0);

    // R3: rounding sum must not wrap; R7 clamps 0x100 to 0xFF
    run_op("R3 R7 round wide", {8{16'hFFFF}}, '0, 0, 8, 3, 1, 0, 0, 0);
    // R3 R4: truncation of the rounded 0x100 keeps 0x00
    run_op("R3 R4 round trunc", {8{16'hFFFF}}, '0, 0, 8, 0, 1, 0, 0, 1);
    // R5: most negative 16-bit lane clamps to 0x80
    run_op("R5 signed min", {8{16'h8000}}, '0, 0, 1, 1, 0, 0, 0, 1);
    // R6: negative goes to zero
    run_op("R6 neg to zero", {8{16'h8000}}, '0, 0, 1, 2, 0, 0, 0, 0);
    // R11: later non-saturating op keeps the flag
    run_op("R11 hold", {8{16'h0010}}, '0, 0, 1, 3, 0, 0, 0, 0);
    // R11: clear wins over simultaneous saturation
    run_op("R11 clear wins", {8{16'hFFFF}}, '0, 0, 1, 3, 0, 0, 0, 1);
    // R12: shift equal to W for 32-bit results
    run_op("R12 shift W", rnd128(), rnd128(), 2, 32, 1, 1, 0, 0, 1);
    run_op("R12 shift W u", rnd128(), rnd128(), 1, 16, 3, 0, 1, 0, 1);
    // R9: upper half write keeps low half
    run_op("R9 upper", {8{16'h0123}}, rnd128(), 0, 2, 3, 0, 1, 0, 1);
    // R10: scalar ignores upper select
    run_op("R10 scalar", rnd128(), rnd128(), 1, 4, 1, 0, 1, 1, 1);
    // R8: lower half write
    run_op("R8 lower", rnd128(), rnd128(), 2, 7, 0, 0, 0, 0, 1);

    for (int k = 0; k < 400; k++) begin
      int sz = $urandom % 3;
      int w = 8 << sz;
      int sh = 1 + ($urandom % w);
      int md = $urandom % 4;
      logic [127:0] s = rnd128();
      string tg;
      if (($urandom % 2) == 0) s = s >> ($urandom % 128);
      if (($urandom % 4) == 0) s = ~s >> ($urandom % 128);
      case (md)
        0: tg = "R2 R4 rand";
        1: tg = "R2 R5 rand";
        2: tg = "R2 R6 rand";
        default: tg = "R2 R7 rand";
      endcase
      run_op(tg, s, rnd128(), sz, sh, md, ($urandom % 2) == 1, ($urandom % 2) == 1,
             ($urandom % 5) == 0, ($urandom % 8) == 0);
    end
    finish_run();
  end
endmodule